// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Engine

The engine raises a 32-bit base to a 32-bit exponent modulo an odd 32-bit modulus. Internally it uses Montgomery multiplication. The base, modulus, exponent and the domain-conversion constant R2 = 2^64 mod M all enter through one 32-bit data port. A 3-bit command code selects the register that captures the word on `data_in`. The same code also starts an exponentiation, keeps a finished result on show, or releases the result so that new work can begin.

Loads are qualified by `data_valid`. The block never applies back-pressure: any load offered while the engine is idle is taken in the same cycle, and loads offered at other times are dropped. `ready` is a plain status flag. While it is high, `result` carries A^B mod M.

Inside the block are four operand registers, a bit-serial radix-2 Montgomery multiplier and a square-and-multiply sequencer. The sequencer scans the exponent from its most significant bit. The caller supplies R2. Operands must satisfy base < M, R2 < M and M odd, M > 1.

Top module: `mexp_engine`

## Requirements
- R1: With `data_valid` high in the idle state, command 0 loads the base, 1 the modulus, 2 the exponent and 3 the constant R2 from `data_in` at the clock edge. Each load replaces only its own register.
- R2: A load command with `data_valid` low changes no operand register.
- R3: Command 4 in the idle state starts a computation. `ready` is low from the next cycle and stays low until the result is written.
- R4: When `ready` rises, `result` equals base^exponent mod modulus and is below the modulus.
- R5: An exponent of zero gives a result of 1.
- R6: While `ready` is high, `ready` stays high and `result` stays unchanged under any command other than 6. Load commands during a computation or while the result is shown change no operand.
- R7: Command 6 while `ready` is high clears `ready` and `result` to 0 on the next cycle. The operand registers are kept, so a new command 4 recomputes with them.
- R8: Command 7 is ignored: it changes neither the operands, nor `ready`, nor `result`.
- R9: After reset, `ready` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Command code (0..3 load, 4 run, 5 show, 6 release, 7 none) |
| data_valid | input | 1 | Qualifies `data_in` for load commands |
| data_in | input | 32 | Shared operand word |
| ready | output | 1 | High while `result` is valid |
| result | output | 32 | A^B mod M, zero when not ready |

## Verification
The table of operands covers several cases, and each tells a different fault apart:
- Two fixed vectors with known answers show the Montgomery arithmetic agrees with plain modular arithmetic.
- A modulus just below 2^32 with an all-ones exponent exercises the widest accumulator values and the final subtraction.
- Tiny moduli, a zero base, an exponent of one and an exponent of zero separate errors in the conversion steps from errors in the bit scan.

Directed runs follow. They offer loads with the qualifier low, loads during a computation, and the unused code, and each is then recomputed. A changed answer exposes a write that should have been blocked. A single reloaded base shows that the loads are independent.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

  localparam int unsigned CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_LD_BASE = 3'd0,
    CMD_LD_MOD  = 3'd1,
    CMD_LD_EXP  = 3'd2,
    CMD_LD_R2   = 3'd3,
    CMD_RUN     = 3'd4,
    CMD_SHOW    = 3'd5,
    CMD_RELEASE = 3'd6,
    CMD_NONE    = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ONE,
    SQ_BASE,
    SQ_SQR,
    SQ_MUL,
    SQ_EXIT,
    SQ_DONE
  } seq_e;

  typedef enum logic [1:0] {
    MM_IDLE,
    MM_RUN,
    MM_FIX
  } mm_e;

  localparam int unsigned N_OPS = 4;

endpackage

// File: rtl/mexp_opbank.sv
module mexp_opbank
  import mexp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [1:0]   ld_sel,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] base_q,
  output logic [W-1:0] mod_q,
  output logic [W-1:0] exp_q,
  output logic [W-1:0] r2_q
);

  logic [W-1:0] regs [N_OPS];

  // one capture register per operand slot, selected by the low command bits
  for (genvar g = 0; g < N_OPS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (ld_en && (ld_sel == 2'(g))) begin
        regs[g] <= ld_data;
      end
    end
  end

  assign base_q = regs[0];
  assign mod_q  = regs[1];
  assign exp_q  = regs[2];
  assign r2_q   = regs[3];

endmodule

// File: rtl/mexp_montmul.sv
module mexp_montmul
  import mexp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] modn,
  output logic         done,
  output logic [W-1:0] prod
);

  // accumulator stays below 2n, one add of b and one of n keep it below 4n
  localparam int unsigned AW = W + 2;
  localparam int unsigned CW = $clog2(W) + 1;

  mm_e          st;
  logic [AW-1:0] acc;
  logic [W-1:0]  a_sh;
  logic [W-1:0]  b_q;
  logic [W-1:0]  n_q;
  logic [CW-1:0] cnt;

  logic [AW-1:0] sum_b;
  logic [AW-1:0] sum_n;
  logic [AW-1:0] acc_sub;

  always_comb begin
    sum_b   = acc + (a_sh[0] ? {2'b00, b_q} : '0);
    sum_n   = sum_b + (sum_b[0] ? {2'b00, n_q} : '0);
    acc_sub = acc - {2'b00, n_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= MM_IDLE;
      acc  <= '0;
      a_sh <= '0;
      b_q  <= '0;
      n_q  <= '0;
      cnt  <= '0;
      done <= 1'b0;
      prod <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        MM_IDLE: begin
          if (start) begin
            acc  <= '0;
            a_sh <= op_a;
            b_q  <= op_b;
            n_q  <= modn;
            cnt  <= '0;
            st   <= MM_RUN;
          end
        end
        MM_RUN: begin
          acc  <= sum_n >> 1;
          a_sh <= a_sh >> 1;
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) st <= MM_FIX;
        end
        MM_FIX: begin
          prod <= (acc >= {2'b00, n_q}) ? acc_sub[W-1:0] : acc[W-1:0];
          done <= 1'b1;
          st   <= MM_IDLE;
        end
        default: st <= MM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mexp_seq.sv
module mexp_seq
  import mexp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         release_res,
  input  logic [W-1:0] base_q,
  input  logic [W-1:0] exp_q,
  input  logic [W-1:0] r2_q,
  output logic         mm_start,
  output logic [W-1:0] mm_a,
  output logic [W-1:0] mm_b,
  input  logic         mm_done,
  input  logic [W-1:0] mm_prod,
  output logic         busy,
  output logic         ready,
  output logic [W-1:0] result
);

  localparam int unsigned BW = $clog2(W);
  localparam logic [W-1:0] ONE = W'(1);

  seq_e          st;
  logic          issued;
  logic [W-1:0]  acc;
  logic [W-1:0]  xb;
  logic [BW-1:0] bit_idx;
  logic          in_calc;

  assign in_calc  = (st != SQ_IDLE) && (st != SQ_DONE);
  assign busy     = in_calc;
  assign ready    = (st == SQ_DONE);
  assign mm_start = in_calc && !issued;

  always_comb begin
    mm_a = '0;
    mm_b = '0;
    case (st)
      SQ_ONE:  begin mm_a = ONE;    mm_b = r2_q; end
      SQ_BASE: begin mm_a = base_q; mm_b = r2_q; end
      SQ_SQR:  begin mm_a = acc;    mm_b = acc;  end
      SQ_MUL:  begin mm_a = acc;    mm_b = xb;   end
      SQ_EXIT: begin mm_a = acc;    mm_b = ONE;  end
      default: begin mm_a = '0;     mm_b = '0;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      issued  <= 1'b0;
      acc     <= '0;
      xb      <= '0;
      bit_idx <= '0;
      result  <= '0;
    end else begin
      if (mm_start) issued <= 1'b1;
      case (st)
        SQ_IDLE: begin
          if (go) begin
            st     <= SQ_ONE;
            issued <= 1'b0;
          end
        end
        SQ_ONE: begin
          if (issued && mm_done) begin
            acc    <= mm_prod;
            issued <= 1'b0;
            st     <= SQ_BASE;
          end
        end
        SQ_BASE: begin
          if (issued && mm_done) begin
            xb      <= mm_prod;
            bit_idx <= BW'(W - 1);
            issued  <= 1'b0;
            st      <= SQ_SQR;
          end
        end
        SQ_SQR: begin
          if (issued && mm_done) begin
            acc    <= mm_prod;
            issued <= 1'b0;
            if (exp_q[bit_idx]) begin
              st <= SQ_MUL;
            end else if (bit_idx == '0) begin
              st <= SQ_EXIT;
            end else begin
              bit_idx <= bit_idx - 1'b1;
            end
          end
        end
        SQ_MUL: begin
          if (issued && mm_done) begin
            acc    <= mm_prod;
            issued <= 1'b0;
            if (bit_idx == '0) begin
              st <= SQ_EXIT;
            end else begin
              bit_idx <= bit_idx - 1'b1;
              st      <= SQ_SQR;
            end
          end
        end
        SQ_EXIT: begin
          if (issued && mm_done) begin
            result <= mm_prod;
            issued <= 1'b0;
            st     <= SQ_DONE;
          end
        end
        SQ_DONE: begin
          if (release_res) begin
            result <= '0;
            st     <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mexp_engine.sv
module mexp_engine
  import mexp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd,
  input  logic             data_valid,
  input  logic [W-1:0]     data_in,
  output logic             ready,
  output logic [W-1:0]     result
);

  cmd_e         cmd_c;
  logic         busy;
  logic         idle;
  logic         ld_en;
  logic         go;
  logic         release_res;
  logic [W-1:0] base_q;
  logic [W-1:0] mod_q;
  logic [W-1:0] exp_q;
  logic [W-1:0] r2_q;
  logic         mm_start;
  logic [W-1:0] mm_a;
  logic [W-1:0] mm_b;
  logic         mm_done;
  logic [W-1:0] mm_prod;

  assign cmd_c       = cmd_e'(cmd);
  assign idle        = !busy && !ready;
  assign ld_en       = idle && data_valid && (cmd[CMD_W-1] == 1'b0);
  assign go          = idle && (cmd_c == CMD_RUN);
  assign release_res = ready && (cmd_c == CMD_RELEASE);

  mexp_opbank #(.W(W)) u_opbank (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (ld_en),
    .ld_sel  (cmd[1:0]),
    .ld_data (data_in),
    .base_q  (base_q),
    .mod_q   (mod_q),
    .exp_q   (exp_q),
    .r2_q    (r2_q)
  );

  mexp_seq #(.W(W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .go          (go),
    .release_res (release_res),
    .base_q      (base_q),
    .exp_q       (exp_q),
    .r2_q        (r2_q),
    .mm_start    (mm_start),
    .mm_a        (mm_a),
    .mm_b        (mm_b),
    .mm_done     (mm_done),
    .mm_prod     (mm_prod),
    .busy        (busy),
    .ready       (ready),
    .result      (result)
  );

  mexp_montmul #(.W(W)) u_montmul (
    .clk   (clk),
    .rst   (rst),
    .start (mm_start),
    .op_a  (mm_a),
    .op_b  (mm_b),
    .modn  (mod_q),
    .done  (mm_done),
    .prod  (mm_prod)
  );

endmodule

// File: rtl/mexp_checker.sv
module mexp_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   cmd,
  input logic         data_valid,
  input logic         ready,
  input logic         busy,
  input logic [W-1:0] result,
  input logic [W-1:0] base_q,
  input logic [W-1:0] mod_q,
  input logic [W-1:0] exp_q,
  input logic [W-1:0] r2_q
);

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (!ready && result == '0));

  p_no_load_invalid_r2: assert property (@(posedge clk) disable iff (rst)
    !data_valid |=> ($stable(base_q) && $stable(mod_q) && $stable(exp_q) && $stable(r2_q)));

  p_ready_not_busy_r3: assert property (@(posedge clk) disable iff (rst)
    !(ready && busy));

  p_ready_after_calc_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(busy));

  p_result_below_mod_r4: assert property (@(posedge clk) disable iff (rst)
    ready |-> (result < mod_q));

  p_hold_shown_r6: assert property (@(posedge clk) disable iff (rst)
    (ready && cmd != 3'd6) |=> (ready && $stable(result)));

  p_frozen_ops_r6: assert property (@(posedge clk) disable iff (rst)
    (busy || ready) |=> ($stable(base_q) && $stable(mod_q) && $stable(exp_q) && $stable(r2_q)));

  p_release_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (ready && cmd == 3'd6) |=> (!ready && result == '0));

  p_code7_inert_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd7 && !busy) |=> ($stable(ready) && $stable(result) && $stable(base_q)
                                && $stable(mod_q) && $stable(exp_q) && $stable(r2_q)));

endmodule

bind mexp_engine mexp_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd        (cmd),
  .data_valid (data_valid),
  .ready      (ready),
  .busy       (busy),
  .result     (result),
  .base_q     (base_q),
  .mod_q      (mod_q),
  .exp_q      (exp_q),
  .r2_q       (r2_q)
);

// File: tb/mexp_engine_bench.sv
module mexp_engine_bench;
  import mexp_pkg::*;

  localparam int CLK_P = 10;
  localparam int W = 32;
  localparam int NV = 8;
  localparam int WAIT_MAX = 6000;

  // {base, exponent, modulus}
  localparam logic [95:0] VEC [NV] = '{
    {32'h075BCD15, 32'h0009FBF1, 32'h8000000B},
    {32'h010D6231, 32'h0006A0A6, 32'h8000002D},
    {32'h00000002, 32'h0000000A, 32'h000F4243},
    {32'hFFFFFFF0, 32'hFFFFFFFF, 32'hFFFFFFFB},
    {32'h00000005, 32'h00000001, 32'h00000007},
    {32'h00000003, 32'h00000000, 32'h00010001},
    {32'h00000000, 32'h00000005, 32'h00000003},
    {32'h00012345, 32'h00000011, 32'h7FFFFFFF}
  };
  localparam logic [31:0] KNOWN_R2  [2] = '{32'h000001E4, 32'h00001FA4};
  localparam logic [31:0] KNOWN_RES [2] = '{32'h14B84766, 32'h4CE8B4F7};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   cmd = 3'd7;
  logic         data_valid = 1'b0;
  logic [W-1:0] data_in = '0;
  logic         ready;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  mexp_engine #(.W(W)) u_mexp_engine (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .data_valid (data_valid),
    .data_in    (data_in),
    .ready      (ready),
    .result     (result)
  );

  function automatic logic [31:0] ref_pow(logic [31:0] b, logic [31:0] e, logic [31:0] m);
    logic [63:0] r;
    logic [63:0] x;
    r = 64'd1 % {32'd0, m};
    x = {32'd0, b} % {32'd0, m};
    for (int i = 0; i < 32; i++) begin
      if (e[i]) r = (r * x) % {32'd0, m};
      x = (x * x) % {32'd0, m};
    end
    return r[31:0];
  endfunction

  function automatic logic [31:0] ref_r2(logic [31:0] m);
    logic [63:0] t;
    t = 64'h1_0000_0000 % {32'd0, m};
    t = (t * t) % {32'd0, m};
    return t[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs change just after a falling edge; outputs are read at the next falling edge
  task automatic drive(logic [2:0] c, logic v, logic [31:0] d);
    cmd = c;
    data_valid = v;
    data_in = d;
    @(negedge clk);
  endtask

  task automatic wait_ready(logic [2:0] c);
    int k;
    k = 0;
    while (!ready && k < WAIT_MAX) begin
      drive(c, 1'b0, '0);
      k++;
    end
    if (!ready) begin
      n_chk++;
      n_bad++;
      $display("FAIL R3 timeout actual=%0d expected=ready", k);
    end
  endtask

  task automatic load_all(logic [31:0] b, logic [31:0] e, logic [31:0] m, logic [31:0] r2);
    drive(3'(CMD_LD_BASE), 1'b1, b);
    drive(3'(CMD_LD_MOD),  1'b1, m);
    drive(3'(CMD_LD_EXP),  1'b1, e);
    drive(3'(CMD_LD_R2),   1'b1, r2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] last_exp;
    logic [31:0] held;
    logic [31:0] nb;
    @(negedge clk);
    @(negedge clk);
    check("R9 ready after reset", 32'(ready), 32'd0);
    check("R9 result after reset", result, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] b, e, m, r2, want;
      b = VEC[i][95:64];
      e = VEC[i][63:32];
      m = VEC[i][31:0];
      r2 = (i < 2) ? KNOWN_R2[i] : ref_r2(m);
      want = ref_pow(b, e, m);
      load_all(b, e, m, r2);
      drive(3'(CMD_RUN), 1'b0, '0);
      check("R3 ready low after start", 32'(ready), 32'd0);
      wait_ready(3'(CMD_RUN));
      check(e == 0 ? "R5 zero exponent" : "R4 result", result, want);
      if (i < 2) check("R4 fixed vector", result, KNOWN_RES[i]);
      held = result;
      repeat (3) drive(3'(CMD_SHOW), 1'b0, '0);
      check("R6 ready held on show", 32'(ready), 32'd1);
      check("R6 result held on show", result, held);
      drive(3'(CMD_RELEASE), 1'b0, '0);
      check("R7 ready cleared", 32'(ready), 32'd0);
      check("R7 result cleared", result, 32'd0);
      last_exp = want;
    end

    // R2: loads without the qualifier are dropped
    drive(3'(CMD_LD_BASE), 1'b0, 32'h0000_1234);
    drive(3'(CMD_LD_MOD),  1'b0, 32'h0000_0005);
    drive(3'(CMD_RUN), 1'b0, '0);
    wait_ready(3'(CMD_SHOW));
    check("R2 unqualified loads ignored", result, last_exp);
    drive(3'(CMD_RELEASE), 1'b0, '0);

    // R8: unused code while idle, then while shown
    drive(3'd7, 1'b1, 32'hDEAD_BEEF);
    check("R8 idle code7 ready", 32'(ready), 32'd0);
    drive(3'(CMD_RUN), 1'b0, '0);
    wait_ready(3'(CMD_SHOW));
    check("R8 code7 operands kept", result, last_exp);
    drive(3'd7, 1'b1, 32'h0000_0001);
    check("R8 shown code7 ready", 32'(ready), 32'd1);
    check("R8 shown code7 result", result, last_exp);
    // R6: loads while the result is shown are dropped
    drive(3'(CMD_LD_EXP), 1'b1, 32'h0000_0003);
    check("R6 load while shown", result, last_exp);
    drive(3'(CMD_RELEASE), 1'b0, '0);

    // R6: loads during a computation are dropped
    drive(3'(CMD_RUN), 1'b0, '0);
    repeat (10) drive(3'(CMD_LD_MOD), 1'b1, 32'h0000_0003);
    wait_ready(3'(CMD_SHOW));
    check("R6 loads while busy ignored", result, last_exp);
    drive(3'(CMD_RELEASE), 1'b0, '0);

    // R1: a single reloaded base changes only the base
    nb = 32'h0ABC_DEF1;
    drive(3'(CMD_LD_BASE), 1'b1, nb);
    drive(3'(CMD_RUN), 1'b0, '0);
    wait_ready(3'(CMD_SHOW));
    check("R1 base reload", result, ref_pow(nb, VEC[NV-1][63:32], VEC[NV-1][31:0]));
    drive(3'(CMD_RELEASE), 1'b0, '0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule